// File: doc/BRIEF.md
# Fetch Line Buffer with Refusal Retry

This block sits at the front of a multi-threaded instruction fetch stage. For each hardware thread it keeps one 64-byte instruction line, and in every cycle it turns the fetch PC of the selected thread into up to W 32-bit instruction words. When the selected thread's line does not cover the PC, it sends a line read to the memory side. The memory side can refuse a request and signal later that it is willing to take it again. Responses carry a tag, so a response that arrives after its thread has been squashed or redirected is recognised and thrown away.

Each thread runs a small state machine with three states. RUN means the thread may extract words or issue a request. WAIT_RSP means a line read has been accepted and the block is waiting for the data. WAIT_RETRY means the request was refused and now occupies the single retry slot. The transitions are: issue-accepted (RUN to WAIT_RSP), issue-refused (RUN to WAIT_RETRY), retry-accepted (WAIT_RETRY to WAIT_RSP), fill (WAIT_RSP to RUN when a matching response arrives), and squash (any state to RUN). A global blocked flag shadows the retry slot. While it is set, no thread may start a new request. Extraction on a line that is already buffered carries on regardless.

Extraction is combinational in the fetch cycle. It starts at the word that holds the PC and stops at the end of the line, after W words, or right after a word marked predicted-taken. The block also returns the PC at which the thread should fetch next.

Top module: `fetch_line_buffer`

## Requirements
- R1: A line request carries address = fetch PC with bits [5:0] cleared, and tag = {thread id, per-thread 2-bit request sequence}; the sequence starts at 0 after reset and advances by one for each new request of that thread (refused requests included, retries excluded).
- R2: When the selected thread is in RUN, its line is valid and the line address equals PC[AW-1:6], no request is issued and words are extracted in the same cycle.
- R3: When the selected thread is in RUN and its line misses (and neither R4 nor R10 holds it off), a request is issued in that cycle, the line is marked invalid at the new address, and the thread extracts nothing until a fill.
- R4: A refused request (request valid with ready low) moves its thread to WAIT_RETRY and sets the blocked flag. While blocked, no new request is issued for any thread. A cycle with the retry input high re-presents the held address and tag, and it leaves the blocked state once that request is accepted.
- R5: A response is accepted only if its thread (upper tag bits) is in WAIT_RSP and its sequence matches that thread's outstanding request. Any other response is discarded and pulses the drop output for that cycle.
- R6: A squash puts its thread in RUN at the next edge. If that thread owns the retry slot, the retry is cancelled and the blocked flag clears. A squash suppresses extraction, requests, retry re-presentation and response acceptance for that thread in the same cycle.
- R7: Extraction begins at word index PC[5:2] of the line (word k at bits [32k+31:32k]) and yields words while the index stays below 16 and at most W words are taken.
- R8: If br_taken[i] is set for extracted slot i, extraction ends after slot i and next_pc equals br_target slot i.
- R9: With no predicted-taken slot, next_pc = {PC[AW-1:2],2'b00} + 4 x count; with a count of zero, next_pc equals the fetch PC.
- R10: While the interrupt-pending input is high and PC[1:0] = 0, no new request is issued; hits still extract.
- R11: After reset every line is invalid, every thread is in RUN, the blocked flag is clear, and no request, word or drop pulse is produced while fetch is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_en | input | 1 | A fetch attempt is made this cycle |
| fetch_tid | input | TID_W | Thread selected for fetch |
| fetch_pc | input | AW | Fetch PC of the selected thread |
| br_taken | input | W | Predicted-taken mark for each extraction slot |
| br_target | input | W*AW | Predicted target for each slot, slot i at [i*AW +: AW] |
| irq_pending | input | 1 | Interrupt pending, holds off new requests per R10 |
| squash_valid | input | 1 | Squash the thread named by squash_tid |
| squash_tid | input | TID_W | Thread to squash |
| mem_req_valid | output | 1 | Line read request presented |
| mem_req_addr | output | AW | Line-aligned request address |
| mem_req_tag | output | TAG_W | Request tag {thread, sequence} |
| mem_req_ready | input | 1 | Memory side takes the presented request |
| mem_retry | input | 1 | Memory side invites the refused request again |
| mem_rsp_valid | input | 1 | Line response present |
| mem_rsp_tag | input | TAG_W | Tag of the response |
| mem_rsp_data | input | 512 | Full line, word k at [32k+31:32k] |
| rsp_drop | output | 1 | Response discarded this cycle |
| inst_words | output | W*32 | Extracted words, slot i at [32i +: 32] |
| inst_count | output | CNT_W | Number of valid slots |
| next_pc | output | AW | PC to fetch next for the selected thread |

## Verification
The bench builds the block with its defaults: two threads, four words per cycle, a 32-bit address and a 2-bit request sequence. With two threads, one thread can hold the retry slot while the other is shut out of the port, and a squash of one thread can be checked to leave the other alone. A width of four with sixteen words per line lets a start near the end of a line be cut at the line edge before the width limit, and a predicted-taken mark inside the window end extraction early. The memory model answers after a fixed three-cycle latency, so squashes and forged tags can be placed while a response is still in flight.

// File: rtl/flb_pkg.sv
package flb_pkg;

    localparam int LINE_BYTES     = 64;
    localparam int LINE_BITS      = LINE_BYTES * 8;
    localparam int WORD_BITS      = 32;
    localparam int WORDS_PER_LINE = LINE_BITS / WORD_BITS;
    localparam int OFF_BITS       = $clog2(LINE_BYTES);

    typedef enum logic [1:0] {
        TS_RUN        = 2'd0,
        TS_WAIT_RSP   = 2'd1,
        TS_WAIT_RETRY = 2'd2
    } thr_state_e;

endpackage

// File: rtl/flb_line_store.sv
module flb_line_store
    import flb_pkg::*;
#(
    parameter int NT    = 2,
    parameter int AW    = 32,
    parameter int TID_W = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rec_en,
    input  logic [TID_W-1:0]     rec_tid,
    input  logic [AW-1:0]        rec_addr,
    input  logic                 fill_en,
    input  logic [TID_W-1:0]     fill_tid,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic [TID_W-1:0]     rd_tid,
    input  logic [AW-1:0]        rd_pc,
    output logic                 rd_hit,
    output logic [LINE_BITS-1:0] rd_line
);

    localparam int TAGB = AW - OFF_BITS;

    logic [TAGB-1:0]      line_tag_q [NT];
    logic [NT-1:0]        line_vld_q;
    logic [LINE_BITS-1:0] line_dat_q [NT];

    for (genvar t = 0; t < NT; t++) begin : g_thr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_tag_q[t] <= '0;
                line_vld_q[t] <= 1'b0;
                line_dat_q[t] <= '0;
            end else if (rec_en && rec_tid == TID_W'(t)) begin
                line_tag_q[t] <= rec_addr[AW-1:OFF_BITS];
                line_vld_q[t] <= 1'b0;
            end else if (fill_en && fill_tid == TID_W'(t)) begin
                line_dat_q[t] <= fill_data;
                line_vld_q[t] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_hit  = line_vld_q[rd_tid] && (line_tag_q[rd_tid] == rd_pc[AW-1:OFF_BITS]);
        rd_line = line_dat_q[rd_tid];
    end

endmodule

// File: rtl/flb_extract.sv
module flb_extract
    import flb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int W     = 4,
    parameter int CNT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [AW-1:0]        pc,
    input  logic [LINE_BITS-1:0] line,
    input  logic [W-1:0]         br_taken,
    input  logic [W*AW-1:0]      br_target,
    output logic [W*WORD_BITS-1:0] words,
    output logic [CNT_W-1:0]     count,
    output logic [AW-1:0]        npc
);

    logic          taken;
    logic [AW-1:0] seq_base;
    int            idx;

    always_comb begin
        words    = '0;
        count    = '0;
        taken    = 1'b0;
        npc      = pc;
        seq_base = {pc[AW-1:2], 2'b00};
        idx      = 0;
        if (en) begin
            for (int i = 0; i < W; i++) begin
                idx = int'(pc[OFF_BITS-1:2]) + i;
                if (!taken && idx < WORDS_PER_LINE) begin
                    words[i*WORD_BITS +: WORD_BITS] = line[idx*WORD_BITS +: WORD_BITS];
                    count = count + CNT_W'(1);
                    if (br_taken[i]) begin
                        taken = 1'b1;
                        npc   = br_target[i*AW +: AW];
                    end
                end
            end
            if (!taken) begin
                npc = seq_base + AW'({count, 2'b00});
            end
        end
    end

    AST_LINE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (int'(pc[OFF_BITS-1:2]) + int'(count) <= WORDS_PER_LINE)) else $error("line edge"); // R7
    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= W) else $error("width cap"); // R7

endmodule

// File: rtl/flb_req_ctrl.sv
module flb_req_ctrl
    import flb_pkg::*;
#(
    parameter int NT    = 2,
    parameter int AW    = 32,
    parameter int SEQ_W = 2,
    parameter int TID_W = 1,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_en,
    input  logic [TID_W-1:0] fetch_tid,
    input  logic [AW-1:0]    fetch_pc,
    input  logic             line_hit,
    input  logic             irq_pending,
    input  logic             squash_valid,
    input  logic [TID_W-1:0] squash_tid,
    input  logic             mem_req_ready,
    input  logic             mem_retry,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    output logic             mem_req_valid,
    output logic [AW-1:0]    mem_req_addr,
    output logic [TAG_W-1:0] mem_req_tag,
    output logic             fetch_run,
    output logic             new_req,
    output logic             fill_en,
    output logic [TID_W-1:0] fill_tid,
    output logic             rsp_drop
);

    thr_state_e       st_q   [NT];
    thr_state_e       st_d   [NT];
    logic [SEQ_W-1:0] seq_q  [NT];
    logic [SEQ_W-1:0] seq_d  [NT];
    logic [SEQ_W-1:0] oseq_q [NT];
    logic [SEQ_W-1:0] oseq_d [NT];

    logic             blocked_q, blocked_d;
    logic [TID_W-1:0] rtid_q, rtid_d;
    logic [AW-1:0]    raddr_q, raddr_d;
    logic [TAG_W-1:0] rtag_q, rtag_d;

    logic             resend;
    logic             fetch_sq;
    logic             owner_sq;
    logic [TID_W-1:0] rsp_tid;
    logic [SEQ_W-1:0] rsp_seq;
    logic [AW-1:0]    line_addr;
    logic [NT-1:0]    in_retry;

    // Output / decision logic
    always_comb begin
        owner_sq  = squash_valid && (squash_tid == rtid_q);
        fetch_sq  = squash_valid && (squash_tid == fetch_tid);
        resend    = blocked_q && mem_retry && !owner_sq;
        fetch_run = fetch_en && !fetch_sq && (st_q[fetch_tid] == TS_RUN);
        line_addr = {fetch_pc[AW-1:OFF_BITS], {OFF_BITS{1'b0}}};
        new_req   = fetch_run && !line_hit && !blocked_q &&
                    !(irq_pending && (fetch_pc[1:0] == 2'b00));

        mem_req_valid = resend || new_req;
        mem_req_addr  = resend ? raddr_q : line_addr;
        mem_req_tag   = resend ? rtag_q  : {fetch_tid, seq_q[fetch_tid]};

        rsp_tid  = rsp_tag[TAG_W-1:SEQ_W];
        rsp_seq  = rsp_tag[SEQ_W-1:0];
        fill_tid = rsp_tid;
        fill_en  = rsp_valid && (st_q[rsp_tid] == TS_WAIT_RSP) &&
                   (oseq_q[rsp_tid] == rsp_seq) &&
                   !(squash_valid && squash_tid == rsp_tid);
        rsp_drop = rsp_valid && !fill_en;
    end

    // Next-state logic
    always_comb begin
        blocked_d = blocked_q;
        rtid_d    = rtid_q;
        raddr_d   = raddr_q;
        rtag_d    = rtag_q;
        for (int t = 0; t < NT; t++) begin
            st_d[t]   = st_q[t];
            seq_d[t]  = seq_q[t];
            oseq_d[t] = oseq_q[t];
            unique case (st_q[t])
                TS_RUN: begin
                    if (new_req && fetch_tid == TID_W'(t)) begin
                        seq_d[t]  = seq_q[t] + SEQ_W'(1);
                        oseq_d[t] = seq_q[t];
                        st_d[t]   = mem_req_ready ? TS_WAIT_RSP : TS_WAIT_RETRY;
                    end
                end
                TS_WAIT_RSP: begin
                    if (fill_en && rsp_tid == TID_W'(t)) st_d[t] = TS_RUN;
                end
                TS_WAIT_RETRY: begin
                    if (resend && mem_req_ready && rtid_q == TID_W'(t)) st_d[t] = TS_WAIT_RSP;
                end
                default: st_d[t] = TS_RUN;
            endcase
            if (squash_valid && squash_tid == TID_W'(t)) st_d[t] = TS_RUN;
        end
        if (new_req && !mem_req_ready) begin
            blocked_d = 1'b1;
            rtid_d    = fetch_tid;
            raddr_d   = line_addr;
            rtag_d    = {fetch_tid, seq_q[fetch_tid]};
        end
        if (resend && mem_req_ready) blocked_d = 1'b0;
        if (blocked_q && owner_sq)   blocked_d = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                st_q[t]   <= TS_RUN;
                seq_q[t]  <= '0;
                oseq_q[t] <= '0;
            end
            blocked_q <= 1'b0;
            rtid_q    <= '0;
            raddr_q   <= '0;
            rtag_q    <= '0;
        end else begin
            for (int t = 0; t < NT; t++) begin
                st_q[t]   <= st_d[t];
                seq_q[t]  <= seq_d[t];
                oseq_q[t] <= oseq_d[t];
            end
            blocked_q <= blocked_d;
            rtid_q    <= rtid_d;
            raddr_q   <= raddr_d;
            rtag_q    <= rtag_d;
        end
    end

    always_comb begin
        for (int t = 0; t < NT; t++) in_retry[t] = (st_q[t] == TS_WAIT_RETRY);
    end

    AST_ONE_RETRY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_retry) == (blocked_q ? 1 : 0)) else $error("retry slot"); // R4
    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_q && !mem_retry) |-> !mem_req_valid) else $error("blocked request"); // R4
    AST_BLOCK_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_q && !mem_retry && !owner_sq) |=> (blocked_q && $stable(raddr_q))) else $error("block lost"); // R4
    AST_SQUASH_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_q && owner_sq) |=> !blocked_q) else $error("squash unblock"); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && fetch_pc[1:0] == 2'b00 && !mem_retry) |-> !mem_req_valid) else $error("irq hold"); // R10

endmodule

// File: rtl/fetch_line_buffer.sv
module fetch_line_buffer
    import flb_pkg::*;
#(
    parameter int NT    = 2,
    parameter int W     = 4,
    parameter int AW    = 32,
    parameter int SEQ_W = 2,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
    localparam int TAG_W = TID_W + SEQ_W,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_en,
    input  logic [TID_W-1:0]       fetch_tid,
    input  logic [AW-1:0]          fetch_pc,
    input  logic [W-1:0]           br_taken,
    input  logic [W*AW-1:0]        br_target,
    input  logic                   irq_pending,
    input  logic                   squash_valid,
    input  logic [TID_W-1:0]       squash_tid,
    output logic                   mem_req_valid,
    output logic [AW-1:0]          mem_req_addr,
    output logic [TAG_W-1:0]       mem_req_tag,
    input  logic                   mem_req_ready,
    input  logic                   mem_retry,
    input  logic                   mem_rsp_valid,
    input  logic [TAG_W-1:0]       mem_rsp_tag,
    input  logic [LINE_BITS-1:0]   mem_rsp_data,
    output logic                   rsp_drop,
    output logic [W*WORD_BITS-1:0] inst_words,
    output logic [CNT_W-1:0]       inst_count,
    output logic [AW-1:0]          next_pc
);

    logic                 line_hit;
    logic [LINE_BITS-1:0] line_data;
    logic                 fetch_run;
    logic                 new_req;
    logic                 fill_en;
    logic [TID_W-1:0]     fill_tid;
    logic                 extract_en;

    flb_req_ctrl #(
        .NT(NT), .AW(AW), .SEQ_W(SEQ_W), .TID_W(TID_W), .TAG_W(TAG_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_en     (fetch_en),
        .fetch_tid    (fetch_tid),
        .fetch_pc     (fetch_pc),
        .line_hit     (line_hit),
        .irq_pending  (irq_pending),
        .squash_valid (squash_valid),
        .squash_tid   (squash_tid),
        .mem_req_ready(mem_req_ready),
        .mem_retry    (mem_retry),
        .rsp_valid    (mem_rsp_valid),
        .rsp_tag      (mem_rsp_tag),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_req_tag  (mem_req_tag),
        .fetch_run    (fetch_run),
        .new_req      (new_req),
        .fill_en      (fill_en),
        .fill_tid     (fill_tid),
        .rsp_drop     (rsp_drop)
    );

    flb_line_store #(
        .NT(NT), .AW(AW), .TID_W(TID_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_en   (new_req),
        .rec_tid  (fetch_tid),
        .rec_addr (mem_req_addr),
        .fill_en  (fill_en),
        .fill_tid (fill_tid),
        .fill_data(mem_rsp_data),
        .rd_tid   (fetch_tid),
        .rd_pc    (fetch_pc),
        .rd_hit   (line_hit),
        .rd_line  (line_data)
    );

    assign extract_en = fetch_run && line_hit;

    flb_extract #(
        .AW(AW), .W(W), .CNT_W(CNT_W)
    ) u_extract (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (extract_en),
        .pc       (fetch_pc),
        .line     (line_data),
        .br_taken (br_taken),
        .br_target(br_target),
        .words    (inst_words),
        .count    (inst_count),
        .npc      (next_pc)
    );

    AST_HIT_NO_FETCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (extract_en && !mem_retry) |-> !mem_req_valid) else $error("hit issued request"); // R2
    AST_MISS_NO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        new_req |-> (inst_count == '0)) else $error("miss extracted"); // R3

endmodule

// File: tb/tb_fetch_line_buffer.sv
`timescale 1ns/100ps
module tb_fetch_line_buffer;

    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_en = 1'b0;
    logic [0:0]   fetch_tid = '0;
    logic [31:0]  fetch_pc = '0;
    logic [3:0]   br_taken = '0;
    logic [127:0] br_target;
    logic         irq_pending = 1'b0;
    logic         squash_valid = 1'b0;
    logic [0:0]   squash_tid = '0;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic [2:0]   mem_req_tag;
    logic         mem_req_ready = 1'b1;
    logic         mem_retry = 1'b0;
    logic         mem_rsp_valid = 1'b0;
    logic [2:0]   mem_rsp_tag = '0;
    logic [511:0] mem_rsp_data = '0;
    logic         rsp_drop;
    logic [127:0] inst_words;
    logic [2:0]   inst_count;
    logic [31:0]  next_pc;

    fetch_line_buffer dut (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_tid(fetch_tid),
        .fetch_pc(fetch_pc), .br_taken(br_taken), .br_target(br_target),
        .irq_pending(irq_pending), .squash_valid(squash_valid), .squash_tid(squash_tid),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_req_ready(mem_req_ready), .mem_retry(mem_retry), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data), .rsp_drop(rsp_drop),
        .inst_words(inst_words), .inst_count(inst_count), .next_pc(next_pc)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycle    = 0;
    bit done     = 0;
    bit inject   = 0;

    // reference model state
    int          m_st [2];
    bit          m_lv [2];
    logic [31:0] m_la [2];
    int          m_seq [2];
    int          m_oseq [2];
    bit          m_blk;
    int          m_rtid;
    logic [31:0] m_raddr;
    int          m_rtag;
    logic [31:0] bt [4];

    // memory model queue
    int          q_tag [$];
    logic [31:0] q_addr [$];
    int          q_due [$];

    function automatic logic [511:0] line_of(input logic [31:0] a);
        logic [511:0] d;
        for (int k = 0; k < 16; k++) d[k*32 +: 32] = (a + 32'(4*k)) ^ 32'h5A5A_0000;
        return d;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", rq, what, act, exp, cycle);
        end
    endtask

    task automatic step(input string rq);
        bit sqf, resend, run, hit, newreq, acc, tk, e_rv, e_drop;
        logic [31:0] e_addr, npc, w, line_a;
        int e_tag, off, cnt, rt, rs;
        for (int i = 0; i < 4; i++) br_target[i*32 +: 32] = bt[i];
        if (!inject) begin
            if (q_due.size() > 0 && q_due[0] <= cycle) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_tag   = 3'(q_tag[0]);
                mem_rsp_data  = line_of(q_addr[0]);
                void'(q_tag.pop_front()); void'(q_addr.pop_front()); void'(q_due.pop_front());
            end else begin
                mem_rsp_valid = 1'b0;
            end
        end
        #1;
        // expected outputs
        sqf    = squash_valid && (squash_tid == fetch_tid);
        resend = m_blk && mem_retry && !(squash_valid && int'(squash_tid) == m_rtid);
        run    = fetch_en && !sqf && m_st[fetch_tid] == 0;
        line_a = fetch_pc & ~32'h3F;
        hit    = run && m_lv[fetch_tid] && m_la[fetch_tid] == line_a;
        newreq = run && !hit && !m_blk && !(irq_pending && fetch_pc[1:0] == 2'b00);
        e_rv   = resend || newreq;
        e_addr = resend ? m_raddr : line_a;
        e_tag  = resend ? m_rtag : int'(fetch_tid) * 4 + m_seq[fetch_tid];
        rt     = int'(mem_rsp_tag) >> 2;
        rs     = int'(mem_rsp_tag) & 3;
        acc    = mem_rsp_valid && m_st[rt] == 1 && m_oseq[rt] == rs &&
                 !(squash_valid && int'(squash_tid) == rt);
        e_drop = mem_rsp_valid && !acc;
        chk(mem_req_valid == e_rv, rq, "req_valid", 32'(mem_req_valid), 32'(e_rv));
        if (e_rv) begin
            chk(mem_req_addr == e_addr, rq, "req_addr", mem_req_addr, e_addr);
            chk(int'(mem_req_tag) == e_tag, rq, "req_tag", 32'(mem_req_tag), 32'(e_tag));
        end
        chk(rsp_drop == e_drop, rq, "rsp_drop", 32'(rsp_drop), 32'(e_drop));
        off = int'((fetch_pc & 32'h3F) >> 2);
        cnt = 0; tk = 0; npc = fetch_pc;
        if (hit) begin
            for (int i = 0; i < 4; i++) begin
                if (!tk && off + i < 16) begin
                    w = (m_la[fetch_tid] + 32'(4*(off+i))) ^ 32'h5A5A_0000;
                    chk(inst_words[i*32 +: 32] == w, rq, $sformatf("word%0d", i), inst_words[i*32 +: 32], w);
                    cnt++;
                    if (br_taken[i]) begin tk = 1; npc = bt[i]; end
                end
            end
            if (!tk) npc = (fetch_pc & ~32'h3) + 32'(4*cnt);
        end
        chk(int'(inst_count) == cnt, rq, "inst_count", 32'(inst_count), 32'(cnt));
        chk(next_pc == npc, rq, "next_pc", next_pc, npc);
        // model update
        if (e_rv && mem_req_ready) begin
            q_tag.push_back(e_tag); q_addr.push_back(e_addr); q_due.push_back(cycle + LAT);
        end
        if (acc) begin m_lv[rt] = 1; m_st[rt] = 0; end
        if (resend && mem_req_ready) begin m_st[m_rtid] = 1; m_blk = 0; end
        if (newreq) begin
            m_la[fetch_tid] = line_a; m_lv[fetch_tid] = 0;
            m_oseq[fetch_tid] = m_seq[fetch_tid];
            m_seq[fetch_tid]  = (m_seq[fetch_tid] + 1) % 4;
            if (mem_req_ready) m_st[fetch_tid] = 1;
            else begin
                m_st[fetch_tid] = 2; m_blk = 1; m_rtid = int'(fetch_tid);
                m_raddr = line_a; m_rtag = e_tag;
            end
        end
        if (squash_valid) begin
            m_st[squash_tid] = 0;
            if (m_blk && m_rtid == int'(squash_tid)) m_blk = 0;
        end
        @(posedge clk); cycle++; @(negedge clk);
        inject = 0;
    endtask

    task automatic quiet();
        fetch_en = 0; br_taken = '0; irq_pending = 0; squash_valid = 0;
        mem_req_ready = 1; mem_retry = 0;
        for (int i = 0; i < 4; i++) bt[i] = 32'h0;
    endtask

    task automatic fetch(input int t, input logic [31:0] pc);
        fetch_en = 1; fetch_tid = 1'(t); fetch_pc = pc;
    endtask

    task automatic wait_fill(input int t, input string rq);
        for (int k = 0; k < 12 && m_st[t] != 0; k++) step(rq);
    endtask

    initial begin
        for (int t = 0; t < 2; t++) begin
            m_st[t] = 0; m_lv[t] = 0; m_la[t] = 0; m_seq[t] = 0; m_oseq[t] = 0;
        end
        m_blk = 0; m_rtid = 0; m_raddr = 0; m_rtag = 0;
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state, nothing produced while idle
        step("R11"); step("R11");
        // R3 / R1: miss issues aligned request, then fill
        fetch(0, 32'h0000_0108); step("R3");
        step("R3"); wait_fill(0, "R5");
        // R2 / R9 / R7: hit from offset 2
        fetch(0, 32'h0000_0108); step("R2");
        fetch(0, 32'h0000_0100); step("R9");
        // R7: line edge cuts at 2 words
        fetch(0, 32'h0000_0138); step("R7");
        fetch(0, 32'h0000_0103); step("R9");
        // R8: predicted-taken slot 1
        br_taken = 4'b0010; bt[1] = 32'h0000_2000; fetch(0, 32'h0000_0104); step("R8");
        br_taken = 4'b0001; bt[0] = 32'h0000_3000; fetch(0, 32'h0000_013C); step("R8");
        quiet();
        // R10: interrupt hold-off for thread 1, then low bits nonzero releases it
        irq_pending = 1; fetch(1, 32'h0000_0400); step("R10"); step("R10");
        fetch(0, 32'h0000_0110); step("R10");
        fetch(1, 32'h0000_0401); step("R10");
        quiet(); wait_fill(1, "R3");
        fetch(1, 32'h0000_0404); step("R2");
        // R4: refusal blocks all threads
        mem_req_ready = 0; fetch(0, 32'h0000_0800); step("R4");
        fetch(1, 32'h0000_0900); step("R4"); step("R4");
        fetch(0, 32'h0000_0100); step("R4");
        mem_retry = 1; fetch(1, 32'h0000_0404); step("R4");
        mem_req_ready = 1; step("R4");
        quiet(); wait_fill(0, "R4");
        fetch(0, 32'h0000_0820); step("R4");
        // R6: squash of the retry owner cancels the retry
        mem_req_ready = 0; fetch(0, 32'h0000_0C00); step("R6");
        fetch_en = 0; squash_valid = 1; squash_tid = 0; mem_retry = 1; step("R6");
        quiet(); fetch(1, 32'h0000_0900); step("R6");
        quiet(); wait_fill(1, "R6");
        // R5 / R6: squash while waiting makes the response stale
        fetch(1, 32'h0000_1000); step("R5");
        fetch_en = 0; squash_valid = 1; squash_tid = 1; step("R6");
        squash_valid = 0; repeat (4) step("R5");
        fetch(1, 32'h0000_1000); step("R5");
        quiet(); step("R5");
        // R5: forged tag with wrong sequence is dropped
        inject = 1; mem_rsp_valid = 1; mem_rsp_tag = 3'(4 + ((m_oseq[1] + 1) % 4));
        mem_rsp_data = '1; step("R5");
        mem_rsp_valid = 0; wait_fill(1, "R5");
        fetch(1, 32'h0000_1030); step("R5");
        // R6: squash suppresses same-cycle extraction
        fetch(1, 32'h0000_1030); squash_valid = 1; squash_tid = 1; step("R6");
        quiet(); fetch(1, 32'h0000_1030); step("R6");
        quiet(); step("R11");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule